// File: doc/BRIEF.md
# Interrupt Arbiter and Status Byte Builder

This block sits beside a small 8-bit processor core and decides which hardware interrupt the core should service next. Two active-low request lines arrive asynchronously. The non-maskable line is latched on its falling edge. The maskable line is sampled as a live level and is gated by the core's interrupt-disable flag. When both lines are active, the non-maskable request wins. The arbiter offers one service request to the core through a valid/ready handshake. When the core accepts a request, the block pulses a signal that tells the core to set its interrupt-disable flag.

The block also owns the overflow flag. An external set-overflow pin can only set this flag, and it acts once per rising edge. Software can write the flag at any time.

The block builds the status byte that the core pushes onto the stack. That byte carries a break bit that is not stored anywhere. The break bit reads 1 for a software break or a status push, and 0 for a hardware interrupt entry.

Handshake rules:
- A non-maskable request, once valid, stays valid with its type until the core accepts it.
- A maskable request is a live level. It may be withdrawn before acceptance if the line rises or the mask is set. It may also be displaced by a non-maskable request.
- The core applies back-pressure by holding `svc_ready_i` low.
- Nothing is lost while `svc_ready_i` is low, because the latched edge and the live level both persist.

Top module: `irq_status_arbiter`

## Requirements
- R1: A falling edge on `nmi_n_i` raises a non-maskable service request three clock edges later. Holding the line low yields exactly one request. A new request needs the line to rise and fall again.
- R2: While a non-maskable request is pending, `svc_valid_o` is 1 and `svc_kind_o` is 1 (non-maskable), regardless of the maskable line.
- R3: The maskable request is level-sensitive. If `irq_n_i` is still low and the mask is clear when a non-maskable service is accepted, a maskable request (`svc_kind_o`=0) is offered on the next cycle.
- R4: A maskable request is offered only while the disable flag `core_flags_i[2]` is 0. It appears two clock edges after `irq_n_i` falls.
- R5: `push_byte_o` is formed as follows:
  - bit 7 = N, from `core_flags_i[4]`
  - bit 6 = overflow flag
  - bit 5 = 1
  - bit 4 = break
  - bits 3..0 = D, I, Z, C, from `core_flags_i[3:0]`
- R6: The break bit (`push_byte_o[4]`) depends only on `push_src_i`:
  - 0 when `push_src_i` is 0 (hardware entry)
  - 1 for codes 1 (software break), 2 (status push) and 3
- R7: A rising edge on `ovf_set_i` sets `v_flag_o` three clock edges later. Releasing the pin leaves the flag unchanged.
- R8: A held-high `ovf_set_i` sets the flag only once. A software write (`v_wr_i`, value `v_wr_val_i`) takes effect at the next edge. A pin edge wins over a write in the same cycle.
- R9: `disable_set_o` is 1 exactly in cycles where `svc_valid_o` and `svc_ready_i` are both 1. Accepting a non-maskable request clears the latched request.
- R10: After reset, `svc_valid_o` is 0 and `v_flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n_i | input | 1 | Non-maskable interrupt line, active low, asynchronous |
| irq_n_i | input | 1 | Maskable interrupt line, active low, asynchronous |
| ovf_set_i | input | 1 | Set-overflow pin, active high, asynchronous |
| core_flags_i | input | 5 | Core flags {N, D, I, Z, C}; bit 2 is interrupt-disable |
| push_src_i | input | 2 | Reason for the push: 0 hardware entry, 1 break, 2 status push |
| v_wr_i | input | 1 | Software write strobe for the overflow flag |
| v_wr_val_i | input | 1 | Value for the software write |
| svc_valid_o | output | 1 | Service request valid |
| svc_ready_i | input | 1 | Core accepts the service request |
| svc_kind_o | output | 1 | 1 = non-maskable, 0 = maskable |
| disable_set_o | output | 1 | Pulse: core sets its interrupt-disable flag |
| v_flag_o | output | 1 | Overflow flag |
| push_byte_o | output | 8 | Status byte to push |

## Verification
The hardest situation to reach is a lined-up collision. In one case, both request lines fall together and the non-maskable request must still win after the maskable one has already surfaced through its shorter path. In the other, a pin edge and a software clear of the overflow flag land on the same clock edge. The bench reaches both by counting the synchronizer and edge-detect registers from each input change. It drives the second stimulus so that it meets the first at exactly the edge where the first takes effect. It then holds the request lines low across acceptances to show that the latched edge fires once and that the level request returns.

// File: rtl/ia_pkg.sv
package ia_pkg;
  localparam int STATUS_W = 8;
  localparam int FLAGS_W  = 5;
  // positions inside the pushed byte; the core's pull logic decodes these
  localparam int BIT_N = 7;
  localparam int BIT_V = 6;
  localparam int BIT_ONE = 5;
  localparam int BIT_BRK = 4;
  // position of the disable flag inside core_flags_i
  localparam int FLG_I = 2;

  typedef enum logic [1:0] {
    PUSH_HWINT  = 2'd0,
    PUSH_BREAK  = 2'd1,
    PUSH_STATUS = 2'd2,
    PUSH_RSVD   = 2'd3
  } push_src_e;

  typedef enum logic {
    SVC_MASKABLE = 1'b0,
    SVC_NONMASK  = 1'b1
  } svc_kind_e;
endpackage

// File: rtl/ia_sync.sv
module ia_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RESET_VAL;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= RESET_VAL;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ia_nmi_latch.sv
module ia_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,   // synchronized, active low
  input  logic clear,    // accepted non-maskable service
  output logic pending
);
  logic last_q;
  logic fall;

  assign fall = last_q & ~line_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= 1'b1;
      pending <= 1'b0;
    end else begin
      last_q <= line_n;
      if (fall)       pending <= 1'b1;   // a new edge beats a clear
      else if (clear) pending <= 1'b0;
    end
  end

  assert_nmi_edge_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(fall));
  assert_nmi_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !clear |=> pending);
endmodule

// File: rtl/ia_ovf_flag.sv
module ia_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,      // synchronized, active high
  input  logic wr,
  input  logic wr_val,
  output logic flag
);
  logic last_q;
  logic rise;

  assign rise = pin & ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      last_q <= pin;
      if (rise)    flag <= 1'b1;
      else if (wr) flag <= wr_val;
    end
  end

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !wr |=> flag);
  assert_ovf_set_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(rise || (wr && wr_val)));
  assert_ovf_pin_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> flag);
endmodule

// File: rtl/irq_status_arbiter.sv
module irq_status_arbiter
  import ia_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_n_i,
  input  logic               irq_n_i,
  input  logic               ovf_set_i,
  input  logic [FLAGS_W-1:0] core_flags_i,
  input  logic [1:0]         push_src_i,
  input  logic               v_wr_i,
  input  logic               v_wr_val_i,
  output logic               svc_valid_o,
  input  logic               svc_ready_i,
  output logic               svc_kind_o,
  output logic               disable_set_o,
  output logic               v_flag_o,
  output logic [STATUS_W-1:0] push_byte_o
);
  logic nmi_n_s, irq_n_s, ovf_s;
  logic nmi_pend;
  logic irq_live;
  logic accept;
  logic brk_bit;

  ia_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_nmi (
    .clk(clk), .rst_n(rst_n), .d(nmi_n_i), .q(nmi_n_s));
  ia_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_irq (
    .clk(clk), .rst_n(rst_n), .d(irq_n_i), .q(irq_n_s));
  ia_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_ovf (
    .clk(clk), .rst_n(rst_n), .d(ovf_set_i), .q(ovf_s));

  ia_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .line_n(nmi_n_s),
    .clear(accept && (svc_kind_o == SVC_NONMASK)),
    .pending(nmi_pend));

  ia_ovf_flag u_ovf (
    .clk(clk), .rst_n(rst_n), .pin(ovf_s),
    .wr(v_wr_i), .wr_val(v_wr_val_i), .flag(v_flag_o));

  // arbitration: latched non-maskable edge first, then masked level
  assign irq_live      = ~irq_n_s & ~core_flags_i[FLG_I];
  assign svc_valid_o   = nmi_pend | irq_live;
  assign svc_kind_o    = nmi_pend ? SVC_NONMASK : SVC_MASKABLE;
  assign accept        = svc_valid_o & svc_ready_i;
  assign disable_set_o = accept;

  // status byte: break bit lives only here
  assign brk_bit = (push_src_i != PUSH_HWINT);

  always_comb begin
    push_byte_o          = '0;
    push_byte_o[BIT_N]   = core_flags_i[FLAGS_W-1];
    push_byte_o[BIT_V]   = v_flag_o;
    push_byte_o[BIT_ONE] = 1'b1;
    push_byte_o[BIT_BRK] = brk_bit;
    push_byte_o[3:0]     = core_flags_i[3:0];
  end

  assert_nmi_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (svc_valid_o && svc_kind_o == SVC_NONMASK));
  assert_mask_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid_o && svc_kind_o == SVC_MASKABLE) |-> !core_flags_i[FLG_I]);
  assert_nmi_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid_o && svc_kind_o == SVC_NONMASK && !svc_ready_i) |=>
      (svc_valid_o && svc_kind_o == SVC_NONMASK));
  assert_hw_push_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_src_i == PUSH_HWINT) |-> !push_byte_o[BIT_BRK]);
endmodule

// File: tb/tb_irq_status_arbiter.sv
module tb_irq_status_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1, irq_n = 1'b1, ovf_set = 1'b0;
  logic [4:0] flags = 5'd0;
  logic [1:0] psrc = 2'd0;
  logic v_wr = 1'b0, v_wr_val = 1'b0, ready = 1'b0;
  logic valid, kind, dis_set, vflag;
  logic [7:0] pbyte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_arbiter dut (
    .clk(clk), .rst_n(rst_n), .nmi_n_i(nmi_n), .irq_n_i(irq_n),
    .ovf_set_i(ovf_set), .core_flags_i(flags), .push_src_i(psrc),
    .v_wr_i(v_wr), .v_wr_val_i(v_wr_val), .svc_valid_o(valid),
    .svc_ready_i(ready), .svc_kind_o(kind), .disable_set_o(dis_set),
    .v_flag_o(vflag), .push_byte_o(pbyte));

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk("R10 valid", valid, 0);
    chk("R10 vflag", vflag, 0);

    // R1: single request from a held-low edge
    nmi_n = 1'b0;
    tick(2);
    chk("R1 not yet", valid, 0);
    tick(1);
    chk("R1 valid", valid, 1);
    chk("R1 kind", kind, 1);
    chk("R9 no accept", dis_set, 0);
    tick(3);
    chk("R1 held until accepted", valid, 1);
    ready = 1'b1;
    #1;
    chk("R9 accept pulse", dis_set, 1);
    tick(1);
    ready = 1'b0;
    chk("R9 cleared by accept", valid, 0);
    tick(10);
    chk("R1 held low no repeat", valid, 0);
    nmi_n = 1'b1;
    tick(4);
    nmi_n = 1'b0;
    tick(3);
    chk("R1 second edge", valid, 1);
    ready = 1'b1;
    tick(1);
    ready = 1'b0;
    nmi_n = 1'b1;
    tick(4);

    // R2/R3/R4: both lines fall together
    flags = 5'd0;
    nmi_n = 1'b0;
    irq_n = 1'b0;
    tick(2);
    chk("R4 irq two edges", valid, 1);
    chk("R4 irq kind", kind, 0);
    tick(1);
    chk("R2 nmi wins", kind, 1);
    tick(2);
    chk("R2 nmi still wins", kind, 1);
    ready = 1'b1;
    tick(1);
    ready = 1'b0;
    chk("R3 irq after nmi", valid, 1);
    chk("R3 irq kind", kind, 0);
    flags[2] = 1'b1;  // core sets disable after entry
    #1;
    chk("R4 masked", valid, 0);
    tick(3);
    chk("R4 masked held", valid, 0);
    flags[2] = 1'b0;
    #1;
    chk("R4 unmasked", valid, 1);
    irq_n = 1'b1;
    nmi_n = 1'b1;
    tick(4);
    chk("R4 released", valid, 0);

    // R7/R8 overflow pin
    ovf_set = 1'b1;
    tick(2);
    chk("R7 not yet", vflag, 0);
    tick(1);
    chk("R7 set", vflag, 1);
    v_wr = 1'b1;
    v_wr_val = 1'b0;
    tick(1);
    v_wr = 1'b0;
    chk("R8 sw clear while held", vflag, 0);
    tick(5);
    chk("R8 held sets once", vflag, 0);
    ovf_set = 1'b0;
    tick(3);
    ovf_set = 1'b1;
    tick(3);
    chk("R7 set again", vflag, 1);
    ovf_set = 1'b0;
    tick(5);
    chk("R7 release keeps", vflag, 1);
    v_wr = 1'b1;
    v_wr_val = 1'b0;
    tick(1);
    v_wr = 1'b0;
    chk("R8 write clear", vflag, 0);
    v_wr = 1'b1;
    v_wr_val = 1'b1;
    tick(1);
    v_wr = 1'b0;
    chk("R8 write set", vflag, 1);
    v_wr = 1'b1;
    v_wr_val = 1'b0;
    tick(1);
    v_wr = 1'b0;
    // collision: pin edge meets a clear on the same edge
    ovf_set = 1'b1;
    tick(2);
    v_wr = 1'b1;
    v_wr_val = 1'b0;
    tick(1);
    v_wr = 1'b0;
    chk("R8 pin beats write", vflag, 1);
    ovf_set = 1'b0;
    tick(3);

    // R5/R6 exhaustive push byte sweep
    for (int v = 0; v < 2; v++) begin
      v_wr = 1'b1;
      v_wr_val = v[0];
      tick(1);
      v_wr = 1'b0;
      for (int s = 0; s < 4; s++) begin
        for (int f = 0; f < 32; f++) begin
          logic [7:0] exp;
          psrc = s[1:0];
          flags = f[4:0];
          #1;
          exp = {f[4], v[0], 1'b1, (s != 0), f[3:0]};
          chk((s == 0) ? "R6 hw break clear" : "R5 R6 byte", pbyte, exp);
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule